// File: doc/BRIEF.md
# Program Loader and Pin Front End

This block sits between a small processor core and a narrow set of user pins. It owns a sixteen-entry, byte-wide program memory and decides who may write it on each clock. A mode pin selects between a load mode, in which the user types bytes into the memory or hands an input byte to the core, and a run mode, in which an eight-bit bidirectional pin group turns around and shows the core's output byte.

The three user strobes (start, input acknowledge, memory load) come in unsynchronised. Each passes through a two-flop synchroniser and an edge detector, so a press of any length counts as one event. The byte pins and the address pins go through the same stages, so data and address line up with their strobe. The core's status (input request, halted, program counter) is packed onto a dedicated status byte. The core reads the memory through an asynchronous read port. It writes the memory through a request port that is arbitrated against manual loads.

Top module: `pgm_front_end`

## Requirements
- R1: All eight bits of `bus_oe` equal control pin bit 0 (mode; 1 = run, 0 = load) in the same cycle, with no register in the path.
- R2: `bus_out` equals `cpu_out_byte` while the mode pin is 1 and is 0 while it is 0.
- R3: `stat_pins` carries `cpu_inp_req` at bit 7, `cpu_halted` at bit 6, `cpu_pc` at bits 5:2, and 0 at bits 1:0.
- R4: In load mode, a rising edge on control pin bit 3 writes the byte on `bus_in` into memory at the address on control pin bits 7:4. The new byte is visible on `cpu_mem_rdata` after the third rising clock edge that sees the pin high, and not after the second.
- R5: Holding control pin bit 3 high for many cycles writes once. A byte that changes on `bus_in` while the pin is still held is not stored.
- R6: A rising edge on control pin bit 3 while the mode pin is 1 leaves the memory unchanged.
- R7: In either mode, `cpu_mem_we` writes `cpu_mem_wdata` at `cpu_mem_addr` on the next clock edge, unless a manual write takes that edge.
- R8: When a manual write and a core write fall on the same edge in load mode, the manual byte is stored and the core write is dropped. In run mode the core write is stored and the manual load is ignored.
- R9: A press of control pin bit 1 in run mode gives exactly one `cpu_start` pulse of one cycle, high after the second edge that sees the pin high. In load mode a press gives none.
- R10: A press of control pin bit 2 gives exactly one `cpu_inp_ack` pulse of one cycle, only while `cpu_inp_req` is 1. `cpu_inp_data` carries the `bus_in` byte during that pulse.
- R11: Reset (active low) clears every memory entry to 0 and holds `cpu_start` and `cpu_inp_ack` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_pins | input | 8 | Bit 0 mode, bit 1 start, bit 2 input acknowledge, bit 3 load strobe, bits 7:4 load address |
| bus_in | input | 8 | Byte pins, input side |
| bus_out | output | 8 | Byte pins, output side |
| bus_oe | output | 8 | Per-pin output enable of the byte pins |
| stat_pins | output | 8 | Packed status: input request, halted, program counter |
| cpu_out_byte | input | 8 | Core output register |
| cpu_inp_req | input | 1 | Core waits for an input byte |
| cpu_halted | input | 1 | Core has halted |
| cpu_pc | input | 4 | Core program counter |
| cpu_mem_addr | input | 4 | Core memory address (read and write) |
| cpu_mem_we | input | 1 | Core memory write request |
| cpu_mem_wdata | input | 8 | Core memory write byte |
| cpu_mem_rdata | output | 8 | Memory byte at `cpu_mem_addr` |
| cpu_start | output | 1 | One-cycle start event |
| cpu_inp_ack | output | 1 | One-cycle input-ready event |
| cpu_inp_data | output | 8 | Synchronised input byte |

## Verification
A manual load and a core write request can land on the same clock edge, and the single memory write port must pick one of them. The bench provokes this by raising `cpu_mem_we` in exactly the cycle after the second synchroniser edge of a load press, when the internal load event is live. It aims the two writes at different addresses in load mode and at the same address in run mode. It then reads both addresses back through the core read port: the manual byte must be present and the dropped core address untouched in load mode, and the core byte must be present in run mode.

// File: rtl/pgm_fe_pkg.sv
package pgm_fe_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int CTL_W   = 4 + ADDR_W;

    // control pin positions
    localparam int CTL_MODE     = 0;
    localparam int CTL_START    = 1;
    localparam int CTL_ACK      = 2;
    localparam int CTL_LOAD     = 3;
    localparam int CTL_ADDR_LSB = 4;

    // strobe positions inside the synchroniser vector
    localparam int STB_START = 0;
    localparam int STB_ACK   = 1;
    localparam int STB_LOAD  = 2;
    localparam int STB_N     = 3;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ram_wr_t;

    typedef logic [DEPTH-1:0][DATA_W-1:0] ram_image_t;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int W      = 16,
    parameter int EDGE_W = 3,
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        raw,
    output logic [EDGE_W-1:0]   rise,
    output logic [W-EDGE_W-1:0] held
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [EDGE_W-1:0]        prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[LAST][EDGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.pipe[LAST][EDGE_W-1:0] & ~st_q.prev;
    assign held = st_q.pipe[LAST][W-1:EDGE_W];
endmodule

// File: rtl/ram_port_arb.sv
module ram_port_arb
    import pgm_fe_pkg::*;
(
    input  logic              man_fire,
    input  logic [ADDR_W-1:0] man_addr,
    input  logic [DATA_W-1:0] man_data,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output ram_wr_t           wr
);
    // manual write has the edge when both ask; the core request is dropped
    always_comb begin
        wr.we   = 1'b0;
        wr.addr = cpu_addr;
        wr.data = cpu_data;
        if (man_fire) begin
            wr.we   = 1'b1;
            wr.addr = man_addr;
            wr.data = man_data;
        end else if (cpu_we) begin
            wr.we = 1'b1;
        end
    end
endmodule

// File: rtl/prog_ram.sv
module prog_ram
    import pgm_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ram_wr_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ram_image_t        image
);
    ram_image_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr.we) begin
            mem_d[wr.addr] = wr.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign image   = mem_q;
endmodule

// File: rtl/pgm_front_end.sv
module pgm_front_end
    import pgm_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl_pins,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    output logic [7:0]        stat_pins,
    input  logic [DATA_W-1:0] cpu_out_byte,
    input  logic              cpu_inp_req,
    input  logic              cpu_halted,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [ADDR_W-1:0] cpu_mem_addr,
    input  logic              cpu_mem_we,
    input  logic [DATA_W-1:0] cpu_mem_wdata,
    output logic [DATA_W-1:0] cpu_mem_rdata,
    output logic              cpu_start,
    output logic              cpu_inp_ack,
    output logic [DATA_W-1:0] cpu_inp_data
);
    localparam int HELD_W   = ADDR_W + DATA_W + 1;
    localparam int SYNC_W   = HELD_W + STB_N;
    localparam int STAT_PAD = 8 - 2 - ADDR_W;

    logic [SYNC_W-1:0] sync_raw;
    logic [STB_N-1:0]  stb_rise;
    logic [HELD_W-1:0] held;
    logic              mode_s;
    logic [DATA_W-1:0] data_s;
    logic [ADDR_W-1:0] addr_s;
    logic              man_fire;
    ram_wr_t           ram_wr;
    ram_image_t        ram_image;

    // strobes and their data travel together through the same stages
    assign sync_raw = {ctl_pins[CTL_W-1:CTL_ADDR_LSB], bus_in, ctl_pins[CTL_MODE],
                       ctl_pins[CTL_LOAD], ctl_pins[CTL_ACK], ctl_pins[CTL_START]};

    pin_sync_edge #(
        .W      (SYNC_W),
        .EDGE_W (STB_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (sync_raw),
        .rise  (stb_rise),
        .held  (held)
    );

    assign mode_s = held[0];
    assign data_s = held[DATA_W:1];
    assign addr_s = held[HELD_W-1:DATA_W+1];

    assign man_fire     = stb_rise[STB_LOAD] & ~mode_s;
    assign cpu_start    = stb_rise[STB_START] & mode_s;
    assign cpu_inp_ack  = stb_rise[STB_ACK] & cpu_inp_req;
    assign cpu_inp_data = data_s;

    ram_port_arb u_arb (
        .man_fire (man_fire),
        .man_addr (addr_s),
        .man_data (data_s),
        .cpu_we   (cpu_mem_we),
        .cpu_addr (cpu_mem_addr),
        .cpu_data (cpu_mem_wdata),
        .wr       (ram_wr)
    );

    prog_ram u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ram_wr),
        .rd_addr (cpu_mem_addr),
        .rd_data (cpu_mem_rdata),
        .image   (ram_image)
    );

    // pin direction follows the raw mode pin
    assign bus_oe    = {DATA_W{ctl_pins[CTL_MODE]}};
    assign bus_out   = ctl_pins[CTL_MODE] ? cpu_out_byte : '0;
    assign stat_pins = {cpu_inp_req, cpu_halted, cpu_pc, {STAT_PAD{1'b0}}};
endmodule

// File: rtl/pgm_front_end_chk.sv
module pgm_front_end_chk
    import pgm_fe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              cpu_start,
    input logic              cpu_inp_ack,
    input logic              cpu_inp_req,
    input logic              cpu_mem_we,
    input logic              man_fire,
    input logic [ADDR_W-1:0] addr_s,
    input logic [DATA_W-1:0] data_s,
    input ram_wr_t           ram_wr,
    input ram_image_t        ram_image
);
    assert_oe_uniform_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == '0) || (bus_oe == '1));

    assert_quiet_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == '0) |-> (bus_out == '0));

    assert_ram_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr.we |=> (ram_image[$past(ram_wr.addr)] == $past(ram_wr.data)));

    assert_ram_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr.we |=> $stable(ram_image));

    assert_manual_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (man_fire && cpu_mem_we) |=> (ram_image[$past(addr_s)] == $past(data_s)));

    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> !cpu_start);

    assert_ack_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_inp_ack |-> cpu_inp_req);

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_inp_ack |=> !cpu_inp_ack);
endmodule

bind pgm_front_end pgm_front_end_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_oe      (bus_oe),
    .bus_out     (bus_out),
    .cpu_start   (cpu_start),
    .cpu_inp_ack (cpu_inp_ack),
    .cpu_inp_req (cpu_inp_req),
    .cpu_mem_we  (cpu_mem_we),
    .man_fire    (man_fire),
    .addr_s      (addr_s),
    .data_s      (data_s),
    .ram_wr      (ram_wr),
    .ram_image   (ram_image)
);

// File: tb/pgm_front_end_test.sv
module pgm_front_end_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl_pins = '0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out, bus_oe, stat_pins;
    logic [7:0] cpu_out_byte = '0;
    logic       cpu_inp_req = 1'b0;
    logic       cpu_halted = 1'b0;
    logic [3:0] cpu_pc = '0;
    logic [3:0] cpu_mem_addr = '0;
    logic       cpu_mem_we = 1'b0;
    logic [7:0] cpu_mem_wdata = '0;
    logic [7:0] cpu_mem_rdata;
    logic       cpu_start, cpu_inp_ack;
    logic [7:0] cpu_inp_data;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_ack = 0;
    logic [7:0] ack_byte = '0;

    always #4 clk = ~clk;

    pgm_front_end uut (
        .clk(clk), .rst_n(rst_n), .ctl_pins(ctl_pins), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .stat_pins(stat_pins),
        .cpu_out_byte(cpu_out_byte), .cpu_inp_req(cpu_inp_req),
        .cpu_halted(cpu_halted), .cpu_pc(cpu_pc), .cpu_mem_addr(cpu_mem_addr),
        .cpu_mem_we(cpu_mem_we), .cpu_mem_wdata(cpu_mem_wdata),
        .cpu_mem_rdata(cpu_mem_rdata), .cpu_start(cpu_start),
        .cpu_inp_ack(cpu_inp_ack), .cpu_inp_data(cpu_inp_data)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (cpu_start) n_start <= n_start + 1;
            if (cpu_inp_ack) begin
                n_ack    <= n_ack + 1;
                ack_byte <= cpu_inp_data;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        cpu_mem_addr = a;
        #1;
        v = cpu_mem_rdata;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        ctl_pins[0] = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        chk("R11 start idle", cpu_start, 0);
        chk("R11 ack idle", cpu_inp_ack, 0);
        peek(4'd5, v);
        chk("R11 ram cleared", v, 8'h00);
        chk("R1 oe in load mode", bus_oe, 8'h00);
    endtask

    task automatic t_status();
        @(negedge clk);
        cpu_inp_req = 1'b1; cpu_halted = 1'b0; cpu_pc = 4'hA;
        #1;
        chk("R3 status pattern a", stat_pins, 8'hA8);
        cpu_inp_req = 1'b0; cpu_halted = 1'b1; cpu_pc = 4'h5;
        #1;
        chk("R3 status pattern b", stat_pins, 8'h54);
        cpu_halted = 1'b0;
    endtask

    task automatic t_direction();
        @(negedge clk);
        cpu_out_byte = 8'h3C;
        ctl_pins[0]  = 1'b0;
        #1;
        chk("R1 oe load", bus_oe, 8'h00);
        chk("R2 out load", bus_out, 8'h00);
        ctl_pins[0] = 1'b1;
        #1;
        chk("R1 oe run", bus_oe, 8'hFF);
        chk("R2 out run", bus_out, 8'h3C);
        ctl_pins[0] = 1'b0;
        settle();
    endtask

    task automatic t_load(input logic [3:0] a, input logic [7:0] d, input logic [7:0] old);
        logic [7:0] v;
        @(negedge clk);
        ctl_pins[7:4] = a; bus_in = d; ctl_pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        peek(a, v);
        chk("R4 not yet written", v, old);
        @(negedge clk);
        peek(a, v);
        chk("R4 written", v, d);
        ctl_pins[3] = 1'b0;
        settle();
    endtask

    task automatic t_hold();
        logic [7:0] v;
        @(negedge clk);
        ctl_pins[7:4] = 4'd7; bus_in = 8'h11; ctl_pins[3] = 1'b1;
        repeat (5) @(negedge clk);
        bus_in = 8'h22;
        repeat (6) @(negedge clk);
        ctl_pins[3] = 1'b0;
        settle();
        peek(4'd7, v);
        chk("R5 single write per press", v, 8'h11);
    endtask

    task automatic t_run_ignore();
        logic [7:0] v;
        set_mode(1'b1);
        ctl_pins[7:4] = 4'd3; bus_in = 8'hFF; ctl_pins[3] = 1'b1;
        repeat (4) @(negedge clk);
        ctl_pins[3] = 1'b0;
        settle();
        peek(4'd3, v);
        chk("R6 load ignored in run mode", v, 8'h5A);
        set_mode(1'b0);
    endtask

    task automatic t_cpu_write(input logic m, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] v;
        set_mode(m);
        cpu_mem_addr = a; cpu_mem_wdata = d; cpu_mem_we = 1'b1;
        @(negedge clk);
        cpu_mem_we = 1'b0;
        peek(a, v);
        chk("R7 core write", v, d);
        set_mode(1'b0);
    endtask

    task automatic t_collide_load();
        logic [7:0] v;
        @(negedge clk);
        ctl_pins[7:4] = 4'd4; bus_in = 8'h44; ctl_pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        cpu_mem_addr = 4'd12; cpu_mem_wdata = 8'h99; cpu_mem_we = 1'b1;
        @(negedge clk);
        cpu_mem_we = 1'b0;
        ctl_pins[3] = 1'b0;
        peek(4'd4, v);
        chk("R8 manual wins", v, 8'h44);
        peek(4'd12, v);
        chk("R8 core write dropped", v, 8'h00);
        settle();
    endtask

    task automatic t_collide_run();
        logic [7:0] v;
        set_mode(1'b1);
        ctl_pins[7:4] = 4'd13; bus_in = 8'h55; ctl_pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        cpu_mem_addr = 4'd13; cpu_mem_wdata = 8'hA7; cpu_mem_we = 1'b1;
        @(negedge clk);
        cpu_mem_we = 1'b0;
        ctl_pins[3] = 1'b0;
        peek(4'd13, v);
        chk("R8 core wins in run mode", v, 8'hA7);
        set_mode(1'b0);
    endtask

    task automatic t_start();
        int base;
        base = n_start;
        @(negedge clk);
        ctl_pins[1] = 1'b1;
        repeat (6) @(negedge clk);
        ctl_pins[1] = 1'b0;
        settle();
        chk("R9 no start in load mode", n_start - base, 0);
        set_mode(1'b1);
        base = n_start;
        ctl_pins[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 start pulse high", cpu_start, 1);
        @(negedge clk);
        chk("R9 start pulse ends", cpu_start, 0);
        repeat (6) @(negedge clk);
        ctl_pins[1] = 1'b0;
        settle();
        chk("R9 one start per press", n_start - base, 1);
        set_mode(1'b0);
    endtask

    task automatic t_ack();
        int base;
        base = n_ack;
        cpu_inp_req = 1'b0;
        @(negedge clk);
        bus_in = 8'h33; ctl_pins[2] = 1'b1;
        repeat (5) @(negedge clk);
        ctl_pins[2] = 1'b0;
        settle();
        chk("R10 no ack without request", n_ack - base, 0);
        cpu_inp_req = 1'b1;
        base = n_ack;
        bus_in = 8'h5C; ctl_pins[2] = 1'b1;
        repeat (8) @(negedge clk);
        ctl_pins[2] = 1'b0;
        settle();
        chk("R10 one ack per press", n_ack - base, 1);
        chk("R10 ack byte", ack_byte, 8'h5C);
        cpu_inp_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_direction();
        t_load(4'd3, 8'h5A, 8'h00);
        t_load(4'd15, 8'hC3, 8'h00);
        t_hold();
        t_run_ignore();
        t_cpu_write(1'b1, 4'd9, 8'h77);
        t_cpu_write(1'b0, 4'd10, 8'h66);
        t_collide_load();
        t_collide_run();
        t_start();
        t_ack();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule